// File: doc/BRIEF.md
# Floating-point exception interrupt unit

This unit sits next to a two-lane (high and low) vector floating-point execution pipe. Each completed arithmetic operation arrives with a one-cycle valid strobe. With it come, for each lane, the four exception flags (invalid, divide-by-zero, underflow, overflow) and the guard and sticky rounding bits. The unit compares these against the enable and rounding-mode fields of its status/control register and decides on one of three outcomes: no interrupt, a data interrupt, or a round interrupt.

A data interrupt blocks the destination write of the faulting operation. Either kind of interrupt does the following:
- saves the operation's effective address and the current machine state;
- strips the machine state down to its critical, machine-check and debug enables;
- loads a syndrome word that marks a vector-unit exception;
- emits a vector address built from a prefix register and a per-kind offset register.

Software reaches all eight registers through a simple select/write/read port. Flags that software writes never raise an interrupt. Only the arithmetic strobe is evaluated.

Top module: `fp_exc_unit`

## Requirements
- R1: For each class (invalid, divide-by-zero, underflow, overflow), a strobed result raises a data interrupt when that class's enable is set and its flag is set in the high lane, the low lane, or both. irq_take=1 and irq_data=1 one cycle after the strobe. Flag nibbles are {ovf,unf,dbz,inv} from bit 3 down to bit 0. Enables sit in status bits 15:12 in the same order.
- R2: A software write to any register, including flags together with their enables, never raises irq_take.
- R3: A strobed result raises a round interrupt (irq_take=1, irq_data=0) when the inexact enable (status bit 16) is set and any guard or sticky bit of either lane is set. Each lane's rounding pair is {sticky,guard}.
- R4: A strobed result raises a round interrupt whenever the rounding-mode field (status bits 18:17) is 2'b10 or 2'b11, whatever the flags.
- R5: When data and round conditions hold together, the interrupt is a data interrupt and uses the data offset register.
- R6: wb_en equals res_vld with no data interrupt in that cycle. A round interrupt does not clear it.
- R7: irq_vec = {prefix[31:16], offset[15:4], 4'b0000}. The offset is the data offset register for a data interrupt and the round offset register for a round interrupt.
- R8: On an interrupt, the save-address register receives res_ea and the saved-state register receives the machine state held before the interrupt.
- R9: On an interrupt, the machine state keeps bits 17, 12 and 9 and clears all other bits.
- R10: On an interrupt, the syndrome register becomes 32'h0000_0080 (only bit 7 set).
- R11: Register map on sw_sel: 0 status/control, 1 prefix, 2 data offset, 3 round offset, 4 machine state, 5 save address, 6 saved state, 7 syndrome. Status bits above 18 read zero. A strobed result replaces status bits 11:0 with {hi rounding, lo rounding, hi flags, lo flags} and leaves bits 18:12 unchanged. A strobe takes priority over a software write in the same cycle.
- R12: Reset clears every register and irq_take. Without an interrupt or a software write, the machine state, save and syndrome registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_vld | input | 1 | Arithmetic result valid strobe |
| res_ea | input | 32 | Effective address of the operation |
| res_flg_hi | input | 4 | High-lane flags {ovf,unf,dbz,inv} |
| res_flg_lo | input | 4 | Low-lane flags {ovf,unf,dbz,inv} |
| res_rnd_hi | input | 2 | High-lane {sticky,guard} |
| res_rnd_lo | input | 2 | Low-lane {sticky,guard} |
| wb_en | output | 1 | Destination write permitted |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register select |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected register contents |
| irq_take | output | 1 | Interrupt taken (one-cycle pulse) |
| irq_data | output | 1 | 1 = data interrupt, 0 = round interrupt |
| irq_vec | output | 32 | Vector fetch address |

## Verification
wb_en is combinational and is due in the same cycle as res_vld. irq_take, irq_data and irq_vec are registered, as are all register updates, so they are due at the first rising edge after the strobe. The bench changes inputs on the falling edge. It samples wb_en shortly after driving the strobe, and it samples the interrupt outputs and the register contents (read back through sw_rdata) at the next falling edge. After a software write, the bench watches irq_take on the edges that follow to confirm that it stays low.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int REG_W  = 32;
  localparam int NCLS   = 4;
  localparam int EN_LSB = 12;
  localparam int INX_EN = 16;
  localparam int RM_LSB = 17;
  localparam logic [REG_W-1:0] FSR_MASK = 32'h0007_FFFF;

  typedef enum logic [2:0] {
    SEL_FSR  = 3'd0,
    SEL_PFX  = 3'd1,
    SEL_OFFD = 3'd2,
    SEL_OFFR = 3'd3,
    SEL_MSR  = 3'd4,
    SEL_SRR0 = 3'd5,
    SEL_SRR1 = 3'd6,
    SEL_SYN  = 3'd7
  } reg_sel_e;

  // per-class cause: enable and either lane
  function automatic logic [NCLS-1:0] data_cause(logic [NCLS-1:0] en,
                                                 logic [NCLS-1:0] hi,
                                                 logic [NCLS-1:0] lo);
    return en & (hi | lo);
  endfunction

  // inexact with any rounding bit, or a directed-infinity mode
  function automatic logic round_cause(logic inx_en, logic [1:0] rhi,
                                       logic [1:0] rlo, logic [1:0] mode);
    return (inx_en && (|{rhi, rlo})) || mode[1];
  endfunction

  function automatic logic [REG_W-1:0] vec_addr(logic [15:0] pfx_hi,
                                                logic [11:0] off_mid);
    return {pfx_hi, off_mid, 4'b0000};
  endfunction
endpackage

// File: rtl/fpx_fsr.sv
module fpx_fsr
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic [NCLS-1:0]  flg_hi,
  input  logic [NCLS-1:0]  flg_lo,
  input  logic [1:0]       rnd_hi,
  input  logic [1:0]       rnd_lo,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] fsr
);
  localparam int STAT_W = 2 * NCLS + 4;

  logic [STAT_W-1:0] stat_new;
  assign stat_new = {rnd_hi, rnd_lo, flg_hi, flg_lo};

  always_ff @(posedge clk) begin
    if (!rst_n)       fsr <= '0;
    else if (res_vld) fsr[STAT_W-1:0] <= stat_new;
    else if (wr_en)   fsr <= wdata & FSR_MASK;
  end

  // R11
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> fsr[STAT_W-1:0] == $past(stat_new));
  // R11
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> fsr[REG_W-1:STAT_W] == $past(fsr[REG_W-1:STAT_W]));
endmodule

// File: rtl/fpx_detect.sv
module fpx_detect
  import fpx_pkg::*;
(
  input  logic            res_vld,
  input  logic [6:0]      ctl,
  input  logic [NCLS-1:0] flg_hi,
  input  logic [NCLS-1:0] flg_lo,
  input  logic [1:0]      rnd_hi,
  input  logic [1:0]      rnd_lo,
  output logic            data_hit,
  output logic            round_hit,
  output logic            wb_en
);
  logic [NCLS-1:0] cause;
  assign cause     = data_cause(ctl[NCLS-1:0], flg_hi, flg_lo);
  assign data_hit  = res_vld && (|cause);
  assign round_hit = res_vld && round_cause(ctl[INX_EN-EN_LSB], rnd_hi, rnd_lo,
                                            ctl[RM_LSB-EN_LSB +: 2]);
  assign wb_en     = res_vld && !data_hit;
endmodule

// File: rtl/fpx_state.sv
module fpx_state
  import fpx_pkg::*;
#(
  parameter logic [REG_W-1:0] KEEP    = 32'h0002_1200,
  parameter int               SYN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [REG_W-1:0] ea,
  input  logic             sw_we,
  input  logic [2:0]       sw_sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] pfx,
  output logic [REG_W-1:0] offd,
  output logic [REG_W-1:0] offr,
  output logic [REG_W-1:0] msr,
  output logic [REG_W-1:0] srr0,
  output logic [REG_W-1:0] srr1,
  output logic [REG_W-1:0] syn
);
  localparam logic [REG_W-1:0] SYN_VAL = REG_W'(1) << SYN_BIT;

  reg_sel_e sel;
  assign sel = reg_sel_e'(sw_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx  <= '0;
      offd <= '0;
      offr <= '0;
    end else if (sw_we) begin
      if (sel == SEL_PFX)  pfx  <= wdata;
      if (sel == SEL_OFFD) offd <= wdata;
      if (sel == SEL_OFFR) offr <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr  <= '0;
      srr0 <= '0;
      srr1 <= '0;
      syn  <= '0;
    end else if (take) begin
      srr0 <= ea;
      srr1 <= msr;
      msr  <= msr & KEEP;
      syn  <= SYN_VAL;
    end else if (sw_we) begin
      if (sel == SEL_MSR)  msr  <= wdata;
      if (sel == SEL_SRR0) srr0 <= wdata;
      if (sel == SEL_SRR1) srr1 <= wdata;
      if (sel == SEL_SYN)  syn  <= wdata;
    end
  end

  // R8
  ctx_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> srr0 == $past(ea) && srr1 == $past(msr));
  // R9
  msr_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (msr & ~KEEP) == '0 && (msr & KEEP) == ($past(msr) & KEEP));
  // R10
  syn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $onehot0(syn) && syn[SYN_BIT]);
  // R12
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !sw_we) |=> $stable(msr) && $stable(srr0) && $stable(srr1) && $stable(syn));
endmodule

// File: rtl/fp_exc_unit.sv
module fp_exc_unit
  import fpx_pkg::*;
#(
  parameter int CE_BIT  = 17,
  parameter int ME_BIT  = 12,
  parameter int DE_BIT  = 9,
  parameter int SYN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic [REG_W-1:0] res_ea,
  input  logic [NCLS-1:0]  res_flg_hi,
  input  logic [NCLS-1:0]  res_flg_lo,
  input  logic [1:0]       res_rnd_hi,
  input  logic [1:0]       res_rnd_lo,
  output logic             wb_en,
  input  logic             sw_we,
  input  logic [2:0]       sw_sel,
  input  logic [REG_W-1:0] sw_wdata,
  output logic [REG_W-1:0] sw_rdata,
  output logic             irq_take,
  output logic             irq_data,
  output logic [REG_W-1:0] irq_vec
);
  localparam logic [REG_W-1:0] KEEP =
    (REG_W'(1) << CE_BIT) | (REG_W'(1) << ME_BIT) | (REG_W'(1) << DE_BIT);

  logic [REG_W-1:0] fsr, pfx, offd, offr, msr, srr0, srr1, syn;
  logic data_hit, round_hit, take, fsr_we;
  logic [REG_W-1:0] vec_nxt;

  assign fsr_we = sw_we && (reg_sel_e'(sw_sel) == SEL_FSR);

  fpx_fsr u_fsr (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld),
    .flg_hi(res_flg_hi), .flg_lo(res_flg_lo),
    .rnd_hi(res_rnd_hi), .rnd_lo(res_rnd_lo),
    .wr_en(fsr_we), .wdata(sw_wdata), .fsr(fsr)
  );

  fpx_detect u_det (
    .res_vld(res_vld), .ctl(fsr[EN_LSB +: 7]),
    .flg_hi(res_flg_hi), .flg_lo(res_flg_lo),
    .rnd_hi(res_rnd_hi), .rnd_lo(res_rnd_lo),
    .data_hit(data_hit), .round_hit(round_hit), .wb_en(wb_en)
  );

  assign take = data_hit || round_hit;

  fpx_state #(.KEEP(KEEP), .SYN_BIT(SYN_BIT)) u_st (
    .clk(clk), .rst_n(rst_n), .take(take), .ea(res_ea),
    .sw_we(sw_we), .sw_sel(sw_sel), .wdata(sw_wdata),
    .pfx(pfx), .offd(offd), .offr(offr),
    .msr(msr), .srr0(srr0), .srr1(srr1), .syn(syn)
  );

  assign vec_nxt = data_hit ? vec_addr(pfx[31:16], offd[15:4])
                            : vec_addr(pfx[31:16], offr[15:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_take <= 1'b0;
      irq_data <= 1'b0;
      irq_vec  <= '0;
    end else begin
      irq_take <= take;
      irq_data <= data_hit;
      if (take) irq_vec <= vec_nxt;
    end
  end

  always_comb begin
    case (reg_sel_e'(sw_sel))
      SEL_FSR:  sw_rdata = fsr;
      SEL_PFX:  sw_rdata = pfx;
      SEL_OFFD: sw_rdata = offd;
      SEL_OFFR: sw_rdata = offr;
      SEL_MSR:  sw_rdata = msr;
      SEL_SRR0: sw_rdata = srr0;
      SEL_SRR1: sw_rdata = srr1;
      SEL_SYN:  sw_rdata = syn;
      default:  sw_rdata = '0;
    endcase
  end

  // R1
  data_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |=> irq_take && irq_data);
  // R3
  round_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (round_hit && !data_hit) |=> irq_take && !irq_data);
  // R2
  sw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |=> !irq_take);
  // R6
  wb_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !irq_data);
  // R7
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_vec[3:0] == 4'b0000 && irq_vec[31:16] == pfx[31:16]);
endmodule

// File: tb/fp_exc_unit_test.sv
`timescale 1ns/1ps
module fp_exc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_vld = 1'b0;
  logic [31:0] res_ea = '0;
  logic [3:0]  res_flg_hi = '0, res_flg_lo = '0;
  logic [1:0]  res_rnd_hi = '0, res_rnd_lo = '0;
  logic        wb_en;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_sel = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        irq_take, irq_data;
  logic [31:0] irq_vec;

  int nchk = 0;
  int errs = 0;

  localparam logic [31:0] PFX  = 32'hABCD_1234;
  localparam logic [31:0] OFFD = 32'h0000_5A5F;
  localparam logic [31:0] OFFR = 32'h0000_3C3C;
  localparam logic [31:0] VEC_D = 32'hABCD_5A50;
  localparam logic [31:0] VEC_R = 32'hABCD_3C30;
  localparam logic [31:0] MSR_KEPT = 32'h0002_1200;

  always #10 clk = ~clk;

  fp_exc_unit uut (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ea(res_ea),
    .res_flg_hi(res_flg_hi), .res_flg_lo(res_flg_lo),
    .res_rnd_hi(res_rnd_hi), .res_rnd_lo(res_rnd_lo), .wb_en(wb_en),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .irq_take(irq_take), .irq_data(irq_data), .irq_vec(irq_vec)
  );

  // {ctl[6:0] = {rm[1:0], inx_en, en{ovf,unf,dbz,inv}}, hi, lo, rhi, rlo, take, data}
  localparam int NV = 14;
  localparam logic [20:0] TBL [NV] = '{
    {7'b00_0_0001, 4'h1, 4'h0, 2'b00, 2'b00, 2'b11},  // R1 inv hi
    {7'b00_0_0001, 4'h0, 4'h1, 2'b00, 2'b00, 2'b11},  // R1 inv lo
    {7'b00_0_0001, 4'h0, 4'h8, 2'b00, 2'b00, 2'b00},  // R1 other class
    {7'b00_0_0010, 4'h2, 4'h0, 2'b00, 2'b00, 2'b11},  // R1 dbz
    {7'b00_0_0100, 4'h0, 4'h4, 2'b00, 2'b00, 2'b11},  // R1 unf
    {7'b00_0_1000, 4'h8, 4'h8, 2'b00, 2'b00, 2'b11},  // R1 ovf both lanes
    {7'b00_0_0000, 4'hF, 4'hF, 2'b00, 2'b00, 2'b00},  // R1 no enables
    {7'b00_1_0000, 4'h0, 4'h0, 2'b01, 2'b00, 2'b10},  // R3 hi guard
    {7'b00_1_0000, 4'h0, 4'h0, 2'b00, 2'b10, 2'b10},  // R3 lo sticky
    {7'b00_0_0000, 4'h0, 4'h0, 2'b11, 2'b11, 2'b00},  // R3 inexact off
    {7'b10_0_0000, 4'h0, 4'h0, 2'b00, 2'b00, 2'b10},  // R4 mode 10
    {7'b11_0_0000, 4'h0, 4'h0, 2'b00, 2'b00, 2'b10},  // R4 mode 11
    {7'b01_0_0000, 4'h0, 4'h0, 2'b00, 2'b00, 2'b00},  // R4 mode 01
    {7'b10_1_0001, 4'h0, 4'h1, 2'b01, 2'b00, 2'b11}   // R5 data over round
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sw_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    sw_sel = sel;
    #1;
    d = sw_rdata;
  endtask

  // drive a strobed result at a falling edge; check wb_en at once, irq one edge later
  task automatic arith(input logic [3:0] hi, input logic [3:0] lo, input logic [1:0] rhi,
                       input logic [1:0] rlo, input logic [31:0] ea, input logic exp_wb,
                       input string tag);
    @(negedge clk);
    res_vld = 1'b1; res_flg_hi = hi; res_flg_lo = lo;
    res_rnd_hi = rhi; res_rnd_lo = rlo; res_ea = ea;
    #1;
    chk({tag, " R6 wb_en"}, {31'd0, wb_en}, {31'd0, exp_wb});
    @(negedge clk);
    res_vld = 1'b0; res_flg_hi = '0; res_flg_lo = '0; res_rnd_hi = '0; res_rnd_lo = '0;
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, errs);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 irq_take after reset", {31'd0, irq_take}, 32'd0);
    rd(3'd0, v); chk("R12 status after reset", v, 32'd0);
    rd(3'd4, v); chk("R12 machine state after reset", v, 32'd0);

    sw_wr(3'd1, PFX);
    sw_wr(3'd2, OFFD);
    sw_wr(3'd3, OFFR);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] e;
      logic [31:0] ea;
      e = TBL[i];
      ea = 32'h1000_0000 + 32'(i * 4);
      sw_wr(3'd0, {13'd0, e[20:14], 12'd0});
      sw_wr(3'd4, 32'hFFFF_FFFF);
      arith(e[13:10], e[9:6], e[5:4], e[3:2], ea, !e[0], $sformatf("row%0d", i));
      #1;
      chk($sformatf("row%0d R1/R3/R4 irq_take", i), {31'd0, irq_take}, {31'd0, e[1]});
      if (e[1]) begin
        chk($sformatf("row%0d R5 irq_data", i), {31'd0, irq_data}, {31'd0, e[0]});
        chk($sformatf("row%0d R7 irq_vec", i), irq_vec, e[0] ? VEC_D : VEC_R);
        rd(3'd5, v); chk($sformatf("row%0d R8 save addr", i), v, ea);
        rd(3'd6, v); chk($sformatf("row%0d R8 saved state", i), v, 32'hFFFF_FFFF);
        rd(3'd4, v); chk($sformatf("row%0d R9 machine state", i), v, MSR_KEPT);
        rd(3'd7, v); chk($sformatf("row%0d R10 syndrome", i), v, 32'h0000_0080);
      end else begin
        rd(3'd4, v); chk($sformatf("row%0d R12 machine state held", i), v, 32'hFFFF_FFFF);
      end
    end

    // R2: software sets flags, enables and rounding bits; no interrupt follows
    sw_wr(3'd4, 32'h1234_5678);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = 3'd0; sw_wdata = 32'h0001_FFFF;
    @(negedge clk);
    sw_we = 1'b0;
    chk("R2 no irq after status write", {31'd0, irq_take}, 32'd0);
    @(negedge clk);
    chk("R2 no irq next cycle", {31'd0, irq_take}, 32'd0);
    rd(3'd0, v); chk("R2 status readback", v, 32'h0001_FFFF);
    rd(3'd4, v); chk("R2 machine state untouched", v, 32'h1234_5678);

    // R11: undefined status bits read zero
    sw_wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R11 status mask", v, 32'h0007_FFFF);

    // R11: strobe replaces flag bits, keeps control bits (enables off, mode 00)
    sw_wr(3'd0, 32'h0000_0FFF);
    arith(4'hA, 4'h5, 2'b10, 2'b01, 32'h2000_0000, 1'b1, "R11 load");
    rd(3'd0, v); chk("R11 status after strobe", v, 32'h0000_09A5);

    // R11: strobe wins over a same-cycle software status write
    sw_wr(3'd0, 32'h0000_0000);
    @(negedge clk);
    res_vld = 1'b1; res_flg_hi = 4'h3; res_flg_lo = 4'h0;
    sw_we = 1'b1; sw_sel = 3'd0; sw_wdata = 32'h0000_FFFF;
    @(negedge clk);
    res_vld = 1'b0; res_flg_hi = '0; sw_we = 1'b0;
    rd(3'd0, v); chk("R11 strobe priority", v, 32'h0000_0030);

    $display("CHECKS %0d ERRORS %0d", nchk, errs);
    $finish;
  end
endmodule